// File: doc/BRIEF.md
# Linked Descriptor Transfer Sequencer

This block works through a chain of transfer descriptors kept in memory and hands each one to a data-mover engine. The host writes the address of the first descriptor with a start command. The sequencer then reads that descriptor's five words over a word-read port and starts the mover with the source, destination and byte count it found there. When the mover reports done, the sequencer follows the descriptor's next pointer until it reaches a zero pointer. The host needs to do nothing while the chain runs.

Each descriptor names its own source and destination. A chain can therefore gather scattered source blocks into one contiguous destination region. The sequencer tells the host how the chain went through three sticky event flags and one interrupt line. Whether a completed descriptor raises a flag depends on an interrupt-enable bit in its own control word. Whether that flag is the mid-chain flag or the end-of-chain flag depends on its next pointer. A mover error always raises a flag and stops the chain where it is.

Top module: `chain_seq`

## Requirements
- R1: A start command with a nonzero address while idle sets busy (status bit 3). The block then reads five words at that address and the four word addresses after it, in rising order: next pointer, source, destination, byte count, control.
- R2: After the five reads, `mv_start_o` is high for exactly one cycle and carries that descriptor's source, destination and byte count. A chain built with destinations that follow one another makes the mover see contiguous destination ranges.
- R3: When the mover reports done and the descriptor's next pointer is nonzero, the block fetches and runs the next descriptor with no host action.
- R4: A descriptor that completes with a nonzero next pointer and control bit 0 set sets the end-of-transfer flag (status bit 0).
- R5: A descriptor that completes with a zero next pointer ends the chain and clears busy. If its control bit 0 is set, it also sets the end-of-chain flag (status bit 1).
- R6: A descriptor whose control bit 0 is clear sets no flag and causes no interrupt when it completes.
- R7: A mover error sets the error flag (status bit 2) and raises the interrupt whatever control bit 0 holds. Busy clears and no further descriptor is read or started. `cur_addr_o` keeps the address of the failing descriptor.
- R8: `irq_o` is high exactly when at least one event flag is set, and it stays high until every set flag is cleared. A clear pulse clears the flags whose bits are set in `clr_mask_i` (bit 0 end-of-transfer, bit 1 end-of-chain, bit 2 error) and leaves the others unchanged.
- R9: A start command is ignored while busy. A start command with a zero address sets no flag and causes no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start command pulse |
| start_addr_i | input | 32 | Byte address of the first descriptor |
| clr_i | input | 1 | Flag clear pulse |
| clr_mask_i | input | 3 | Flags to clear (write-one-to-clear) |
| stat_o | output | 4 | {busy, error, end-of-chain, end-of-transfer} |
| cur_addr_o | output | 32 | Address of the current or last descriptor |
| irq_o | output | 1 | Interrupt request |
| rd_req_o | output | 1 | Word read request, held until acknowledged |
| rd_addr_o | output | 32 | Word read byte address |
| rd_ack_i | input | 1 | Read acknowledge with data |
| rd_data_i | input | 32 | Read data |
| mv_start_o | output | 1 | One-cycle mover start |
| mv_src_o | output | 32 | Source address for the mover |
| mv_dst_o | output | 32 | Destination address for the mover |
| mv_len_o | output | 32 | Byte count for the mover |
| mv_done_i | input | 1 | Mover completion pulse |
| mv_err_i | input | 1 | Mover error pulse |

## Verification
The bench builds the block with the package defaults: 32-bit words and five-word descriptors. With these settings every field read from the bench memory lands in a real mover or status output, and the read addresses step by four bytes, so the field order and the address stepping are both observable. Randomized read-acknowledge delays and mover latencies, chains of one to five descriptors with random enable patterns, and errors injected at a random descriptor reach the mixes of mid-chain flag, end-of-chain flag and halt that the requirements separate. A start command issued in the middle of a chain exercises the busy-ignore rule.

// File: rtl/chain_seq_pkg.sv
package chain_seq_pkg;

    parameter int WORD_W     = 32;
    parameter int DESC_WORDS = 5;
    parameter int IE_BIT     = 0;

    localparam int IDX_W   = $clog2(DESC_WORDS);
    localparam int BYTE_SH = $clog2(WORD_W / 8);
    localparam int NFLAG   = 3;

    localparam int FL_EOT  = 0;
    localparam int FL_EOC  = 1;
    localparam int FL_ERR  = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_LAUNCH,
        S_WAIT,
        S_EVAL
    } seq_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] nxt;
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
        logic [WORD_W-1:0] len;
        logic              ie;
    } desc_t;

    function automatic logic [WORD_W-1:0] word_addr(logic [WORD_W-1:0] base,
                                                    logic [IDX_W-1:0]  idx);
        return base + (WORD_W'(idx) << BYTE_SH);
    endfunction

endpackage

// File: rtl/desc_loader.sv
module desc_loader
    import chain_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_i,
    input  logic              ack_i,
    input  logic [WORD_W-1:0] data_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic              last_o,
    output desc_t             desc_o
);
    logic [IDX_W-1:0] idx_q;
    desc_t            d_q;

    assign idx_o  = idx_q;
    assign last_o = ack_i && (idx_q == IDX_W'(DESC_WORDS - 1));
    assign desc_o = d_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            d_q   <= '0;
        end else if (hold_i) begin
            idx_q <= '0;
        end else if (ack_i) begin
            idx_q <= last_o ? '0 : idx_q + 1'b1;
            case (idx_q)
                IDX_W'(0): d_q.nxt <= data_i;
                IDX_W'(1): d_q.src <= data_i;
                IDX_W'(2): d_q.dst <= data_i;
                IDX_W'(3): d_q.len <= data_i;
                default:   d_q.ie  <= data_i[IE_BIT];
            endcase
        end
    end

    AST_LAST_WRAP: assert property (@(posedge clk) disable iff (rst)
        last_o |=> idx_q == '0);  // R1

endmodule

// File: rtl/seq_flags.sv
module seq_flags
    import chain_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             set_eot_i,
    input  logic             set_eoc_i,
    input  logic             set_err_i,
    input  logic             clr_i,
    input  logic [NFLAG-1:0] clr_mask_i,
    output logic [NFLAG-1:0] flags_o,
    output logic             irq_o
);
    logic [NFLAG-1:0] flags_q;
    logic [NFLAG-1:0] set_v;
    logic [NFLAG-1:0] clr_v;

    always_comb begin
        set_v         = '0;
        set_v[FL_EOT] = set_eot_i;
        set_v[FL_EOC] = set_eoc_i;
        set_v[FL_ERR] = set_err_i;
        clr_v         = clr_i ? clr_mask_i : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~clr_v) | set_v;
    end

    assign flags_o = flags_q;
    assign irq_o   = |flags_q;

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        irq_o && !clr_i |=> irq_o);  // R8

    AST_ERR_SETS: assert property (@(posedge clk) disable iff (rst)
        set_err_i |=> flags_o[FL_ERR] && irq_o);  // R7

endmodule

// File: rtl/chain_seq.sv
module chain_seq
    import chain_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [WORD_W-1:0] start_addr_i,
    input  logic              clr_i,
    input  logic [NFLAG-1:0]  clr_mask_i,
    output logic [NFLAG:0]    stat_o,
    output logic [WORD_W-1:0] cur_addr_o,
    output logic              irq_o,
    output logic              rd_req_o,
    output logic [WORD_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic              mv_start_o,
    output logic [WORD_W-1:0] mv_src_o,
    output logic [WORD_W-1:0] mv_dst_o,
    output logic [WORD_W-1:0] mv_len_o,
    input  logic              mv_done_i,
    input  logic              mv_err_i
);
    seq_state_e        state_q;
    logic [WORD_W-1:0] cur_q;
    logic [IDX_W-1:0]  ld_idx;
    logic              ld_last;
    desc_t             desc;
    logic [NFLAG-1:0]  flags;
    logic              last_desc;
    logic              set_eot, set_eoc, set_err;

    desc_loader u_loader (
        .clk    (clk),
        .rst    (rst),
        .hold_i (state_q != S_FETCH),
        .ack_i  (rd_ack_i && state_q == S_FETCH),
        .data_i (rd_data_i),
        .idx_o  (ld_idx),
        .last_o (ld_last),
        .desc_o (desc)
    );

    assign last_desc = (desc.nxt == '0);
    assign set_err   = (state_q == S_WAIT) && mv_err_i;
    assign set_eot   = (state_q == S_EVAL) && desc.ie && !last_desc;
    assign set_eoc   = (state_q == S_EVAL) && desc.ie && last_desc;

    seq_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .set_eot_i  (set_eot),
        .set_eoc_i  (set_eoc),
        .set_err_i  (set_err),
        .clr_i      (clr_i),
        .clr_mask_i (clr_mask_i),
        .flags_o    (flags),
        .irq_o      (irq_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cur_q   <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (start_i && start_addr_i != '0) begin
                    cur_q   <= start_addr_i;
                    state_q <= S_FETCH;
                end
                S_FETCH:  if (ld_last) state_q <= S_LAUNCH;
                S_LAUNCH: state_q <= S_WAIT;
                S_WAIT: begin
                    if (mv_err_i)       state_q <= S_IDLE;
                    else if (mv_done_i) state_q <= S_EVAL;
                end
                S_EVAL: begin
                    if (!last_desc) begin
                        cur_q   <= desc.nxt;
                        state_q <= S_FETCH;
                    end else begin
                        state_q <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign stat_o     = {state_q != S_IDLE, flags};
    assign cur_addr_o = cur_q;
    assign rd_req_o   = (state_q == S_FETCH);
    assign rd_addr_o  = word_addr(cur_q, ld_idx);
    assign mv_start_o = (state_q == S_LAUNCH);
    assign mv_src_o   = desc.src;
    assign mv_dst_o   = desc.dst;
    assign mv_len_o   = desc.len;

    AST_HALT_ON_ERR: assert property (@(posedge clk) disable iff (rst)
        state_q == S_WAIT && mv_err_i |=> state_q == S_IDLE && !rd_req_o && !mv_start_o);  // R7

    AST_LAUNCH_ONCE: assert property (@(posedge clk) disable iff (rst)
        mv_start_o |=> !mv_start_o);  // R2

    AST_ZERO_START: assert property (@(posedge clk) disable iff (rst)
        state_q == S_IDLE && start_i && start_addr_i == '0 |=> state_q == S_IDLE);  // R9

    AST_CUR_HELD: assert property (@(posedge clk) disable iff (rst)
        state_q inside {S_FETCH, S_LAUNCH, S_WAIT} |=> $stable(cur_addr_o));  // R9

endmodule

// File: tb/chain_seq_bench.sv
module chain_seq_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [31:0] start_addr_i;
    logic        clr_i;
    logic [2:0]  clr_mask_i;
    logic [3:0]  stat_o;
    logic [31:0] cur_addr_o;
    logic        irq_o;
    logic        rd_req_o;
    logic [31:0] rd_addr_o;
    logic        rd_ack_i;
    logic [31:0] rd_data_i;
    logic        mv_start_o;
    logic [31:0] mv_src_o, mv_dst_o, mv_len_o;
    logic        mv_done_i, mv_err_i;

    chain_seq u_chain_seq (.*);

    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] mem [0:1023];
    logic [31:0] rd_log[$];
    logic [31:0] src_log[$], dst_log[$], len_log[$];
    logic [31:0] e_addr[5], e_src[5], e_dst[5], e_len[5];
    logic [4:0]  e_ie;
    int          err_at = -1;
    int          mv_cnt = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        finish_sim();
    end

    // word-read responder with random acknowledge latency
    initial begin
        int wt;
        wt = 0;
        rd_ack_i  = 1'b0;
        rd_data_i = '0;
        forever begin
            @(negedge clk);
            if (rd_ack_i) rd_ack_i = 1'b0;
            else if (rd_req_o) begin
                if (wt == 0) begin
                    rd_ack_i  = 1'b1;
                    rd_data_i = mem[rd_addr_o[11:2]];
                    rd_log.push_back(rd_addr_o);
                    wt = $urandom % 3;
                end else wt--;
            end
        end
    end

    // mover stub: done or error pulse after a random delay
    initial begin
        int cnt;
        bit pend;
        pend = 0;
        cnt = 0;
        mv_done_i = 1'b0;
        mv_err_i  = 1'b0;
        forever begin
            @(negedge clk);
            mv_done_i = 1'b0;
            mv_err_i  = 1'b0;
            if (pend) begin
                cnt--;
                if (cnt == 0) begin
                    pend = 0;
                    if (mv_cnt - 1 == err_at) mv_err_i = 1'b1;
                    else mv_done_i = 1'b1;
                end
            end
            if (mv_start_o) begin
                src_log.push_back(mv_src_o);
                dst_log.push_back(mv_dst_o);
                len_log.push_back(mv_len_o);
                mv_cnt++;
                pend = 1;
                cnt = 1 + ($urandom % 4);
            end
        end
    end

    task automatic build(int c, int n, logic [4:0] ie);
        logic [31:0] d;
        d = ($urandom % 4096) << 8;
        e_ie = ie;
        for (int k = 0; k < n; k++) begin
            e_addr[k] = 32'((1 + ((c * 13 + k * 29) % 120)) * 32);
            e_src[k]  = ($urandom % 65536) << 2;
            e_len[k]  = (4 + ($urandom % 16)) << 2;
            e_dst[k]  = d;
            d         = d + e_len[k];
        end
        for (int k = 0; k < n; k++) begin
            mem[e_addr[k][11:2]]     = (k == n - 1) ? 32'd0 : e_addr[k+1];
            mem[e_addr[k][11:2] + 1] = e_src[k];
            mem[e_addr[k][11:2] + 2] = e_dst[k];
            mem[e_addr[k][11:2] + 3] = e_len[k];
            mem[e_addr[k][11:2] + 4] = {$urandom, ie[k]} & 32'hFFFF_FFFF;
        end
    endtask

    task automatic clear_flags(logic [2:0] m);
        @(negedge clk);
        clr_i = 1'b1;
        clr_mask_i = m;
        @(negedge clk);
        clr_i = 1'b0;
        clr_mask_i = '0;
    endtask

    task automatic run(int eidx, bit decoy, output bit irq_seen);
        clear_flags(3'b111);
        rd_log.delete();
        src_log.delete();
        dst_log.delete();
        len_log.delete();
        err_at = eidx;
        mv_cnt = 0;
        start_i = 1'b1;
        start_addr_i = e_addr[0];
        @(negedge clk);
        start_i = 1'b0;
        irq_seen = 0;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            if (decoy && cyc == 4) begin
                start_i = 1'b1;
                start_addr_i = 32'd4064;
            end else start_i = 1'b0;
            if (irq_o) irq_seen = 1;
            if (!stat_o[3]) break;
            @(negedge clk);
        end
        start_i = 1'b0;
        err_at = -1;
    endtask

    task automatic verify(int n, int eidx, bit irq_seen);
        int starts;
        logic eot, eoc, er;
        starts = (eidx >= 0) ? eidx + 1 : n;
        chk("R3 descriptors run", 32'(src_log.size()), 32'(starts));
        chk("R1 word reads", 32'(rd_log.size()), 32'(5 * starts));
        for (int i = 0; i < 5 && i < rd_log.size(); i++)
            chk("R1 read address", rd_log[i], e_addr[0] + 32'(4 * i));
        for (int i = 0; i < starts && i < src_log.size(); i++) begin
            chk("R2 src", src_log[i], e_src[i]);
            chk("R2 dst", dst_log[i], e_dst[i]);
            chk("R2 len", len_log[i], e_len[i]);
            if (i > 0) chk("R2 contiguous dst", dst_log[i], dst_log[i-1] + len_log[i-1]);
        end
        eot = 1'b0;
        for (int i = 0; i < ((eidx >= 0) ? eidx : n - 1); i++) eot |= e_ie[i];
        eoc = (eidx < 0) && e_ie[n-1];
        er  = (eidx >= 0);
        chk("R4 eot flag", 32'(stat_o[0]), 32'(eot));
        chk("R5 eoc flag", 32'(stat_o[1]), 32'(eoc));
        chk("R7 err flag", 32'(stat_o[2]), 32'(er));
        chk("R5 busy clear", 32'(stat_o[3]), 32'd0);
        chk("R8 irq level", 32'(irq_o), 32'(eot | eoc | er));
        if (er) chk("R7 cur addr", cur_addr_o, e_addr[eidx]);
        if (!er && e_ie == 5'b0) chk("R6 no irq", 32'(irq_seen), 32'd0);
    endtask

    initial begin
        bit seen;
        void'($urandom(32'h1F2E3D4C));
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        rst = 1'b1;
        start_i = 1'b0;
        start_addr_i = '0;
        clr_i = 1'b0;
        clr_mask_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 reset status", 32'(stat_o), 32'd0);
        chk("R8 reset irq", 32'(irq_o), 32'd0);
        chk("R1 reset no read", 32'(rd_req_o), 32'd0);

        // R9 zero address start
        start_i = 1'b1;
        start_addr_i = '0;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9 zero start status", 32'(stat_o), 32'd0);
        chk("R9 zero start reads", 32'(rd_log.size()), 32'd0);

        // single descriptor with enable
        build(1, 1, 5'b00001);
        run(-1, 0, seen);
        verify(1, -1, seen);

        // R8 write-one-to-clear sequence
        build(2, 2, 5'b00011);
        run(-1, 0, seen);
        verify(2, -1, seen);
        clear_flags(3'b001);
        chk("R8 partial clear", 32'(stat_o), 32'd2);
        chk("R8 irq held", 32'(irq_o), 32'd1);
        clear_flags(3'b100);
        chk("R8 clear unset bit", 32'(stat_o), 32'd2);
        clear_flags(3'b010);
        chk("R8 all cleared", 32'(stat_o), 32'd0);
        chk("R8 irq drops", 32'(irq_o), 32'd0);

        // R6 no enables across a chain
        build(3, 4, 5'b00000);
        run(-1, 0, seen);
        verify(4, -1, seen);

        // R7 error mid-chain with enables clear
        build(4, 3, 5'b00000);
        run(1, 0, seen);
        verify(3, 1, seen);

        // R9 start while busy
        build(5, 3, 5'b00101);
        run(-1, 1, seen);
        verify(3, -1, seen);

        for (int c = 6; c < 46; c++) begin
            int n, e;
            n = 1 + ($urandom % 5);
            e = (($urandom % 4) == 0) ? int'($urandom % n) : -1;
            build(c, n, 5'($urandom));
            run(e, ($urandom % 3) == 0, seen);
            verify(n, e, seen);
        end
        finish_sim();
    end
endmodule